// File: doc/BRIEF.md
# Dual-Ring Loop Filter State Machine

This block is the digital loop filter of a phase-tracking loop. Each clock it takes two early votes and two late votes from a phase detector. It moves through a twelve-state machine made of two rings of six states. One ring holds net early evidence and the other holds net late evidence. The shared entry state stands for zero accumulated error.

When a ring has been walked all the way round, the block emits a one-cycle pulse to the phase counter downstream. A completed early ring gives an up pulse and a completed late ring gives a down pulse. Any step left over from that cycle is kept inside the same ring.

Each cycle the machine can move zero, one or two states. Because a full ring is needed before each correction, corrections always have a minimum spacing. This spacing keeps the latency of the rest of the loop from causing false steps. The ring length defaults to six and is a parameter. The number of votes per direction is also a parameter.

Top module: `lfr_dual_ring`

## Requirements
- R1: While `rst_n` is low, `up_o` and `down_o` are 0. After reset the machine is at the shared entry state, so exactly six net early steps are needed before the first up pulse.
- R2: The step of a cycle is the number of 1 bits in `early_i` minus the number of 1 bits in `late_i`. A bit set to 1 is a vote. An early bit and a late bit at the same position cancel each other.
- R3: A cycle whose step is zero leaves the state unchanged and produces no pulse.
- R4: When the accumulated position reaches +6 or more, `up_o` is high for exactly the one cycle after the clock edge that sampled the completing votes.
- R5: When the accumulated position reaches -6 or less, `down_o` is high for exactly the one cycle after the clock edge that sampled the completing votes.
- R6: When a ring is completed, the amount by which the position passed the ring end stays in the same ring. For example, +2 from the fifth early state gives an up pulse and lands one state into the early ring.
- R7: A step against the current ring first walks back toward the entry state. The part of the step that goes past zero enters the other ring.
- R8: `up_o` and `down_o` are never high in the same cycle, and neither one is high in two cycles in a row.
- R9: Any two pulses, up or down, are separated by at least three clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| early_i | input | 2 | Early votes, one per bit, 1 = vote |
| late_i | input | 2 | Late votes, one per bit, 1 = vote |
| up_o | output | 1 | Registered one-cycle advance pulse |
| down_o | output | 1 | Registered one-cycle retard pulse |

## Verification
Two functions can land in the same cycle: a ring completion that pulses, and the carry of the leftover step into the same ring. The bench provokes this by placing the machine on the fifth early state and then giving a double early step. The result is judged through the timing of the next up pulse, which must come after exactly five more net steps. The mirror case is provoked on the late side. A behavioural model keeps a plain integer position and is compared with both pulse outputs every cycle, over directed runs and a long stream of pseudo-random votes.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

   typedef enum logic {
      RING_EARLY = 1'b0,
      RING_LATE  = 1'b1
   } ring_e;

endpackage

// File: rtl/lfr_vote_net.sv
module lfr_vote_net #(
   parameter int VOTE_W = 2,
   localparam int CNT_W = $clog2(VOTE_W + 1),
   localparam int NET_W = CNT_W + 1
) (
   input  logic [VOTE_W-1:0]       early_i,
   input  logic [VOTE_W-1:0]       late_i,
   output logic signed [NET_W-1:0] net_o
);

   logic [CNT_W-1:0] cnt_early;
   logic [CNT_W-1:0] cnt_late;

   always_comb begin
      cnt_early = '0;
      cnt_late  = '0;
      for (int i = 0; i < VOTE_W; i++) begin
         cnt_early = cnt_early + CNT_W'(early_i[i]);
         cnt_late  = cnt_late  + CNT_W'(late_i[i]);
      end
   end

   assign net_o = signed'({1'b0, cnt_early}) - signed'({1'b0, cnt_late});

endmodule

// File: rtl/lfr_ring_next.sv
module lfr_ring_next
   import lfr_pkg::*;
#(
   parameter int RING_LEN = 6,
   parameter int NET_W    = 3,
   parameter int MAX_STEP = 2,
   localparam int IDX_W   = $clog2(RING_LEN),
   localparam int POS_W   = $clog2(RING_LEN + MAX_STEP) + 2
) (
   input  ring_e                   ring_i,
   input  logic [IDX_W-1:0]        idx_i,
   input  logic signed [NET_W-1:0] net_i,
   output ring_e                   ring_o,
   output logic [IDX_W-1:0]        idx_o,
   output logic                    fire_up_o,
   output logic                    fire_dn_o
);

   localparam logic signed [POS_W-1:0] LEN_S = POS_W'(RING_LEN);

   logic signed [POS_W-1:0] mag;
   logic signed [POS_W-1:0] pos;
   logic signed [POS_W-1:0] tgt;
   logic signed [POS_W-1:0] rem;

   always_comb begin
      mag = signed'(POS_W'(idx_i));
      pos = (ring_i == RING_EARLY) ? mag : -mag;
      tgt = pos + POS_W'(net_i);
      fire_up_o = 1'b0;
      fire_dn_o = 1'b0;
      ring_o    = ring_i;
      rem       = '0;
      if (tgt >= LEN_S) begin
         fire_up_o = 1'b1;
         ring_o    = RING_EARLY;
         rem       = tgt - LEN_S;
      end else if (tgt <= -LEN_S) begin
         fire_dn_o = 1'b1;
         ring_o    = RING_LATE;
         rem       = -tgt - LEN_S;
      end else if (tgt > 0) begin
         ring_o = RING_EARLY;
         rem    = tgt;
      end else if (tgt < 0) begin
         ring_o = RING_LATE;
         rem    = -tgt;
      end
      idx_o = rem[IDX_W-1:0];
   end

endmodule

// File: rtl/lfr_dual_ring.sv
module lfr_dual_ring
   import lfr_pkg::*;
#(
   parameter int RING_LEN = 6,
   parameter int VOTE_W   = 2,
   localparam int MAX_STEP = VOTE_W,
   localparam int CNT_W    = $clog2(VOTE_W + 1),
   localparam int NET_W    = CNT_W + 1,
   localparam int IDX_W    = $clog2(RING_LEN),
   localparam int MIN_GAP  = (RING_LEN + MAX_STEP - 1) / MAX_STEP,
   localparam int GAP_W    = $clog2(MIN_GAP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VOTE_W-1:0] early_i,
   input  logic [VOTE_W-1:0] late_i,
   output logic              up_o,
   output logic              down_o
);

   generate
      if (RING_LEN <= MAX_STEP) begin : g_bad_len
         $error("RING_LEN must exceed the largest single-cycle step");
      end
      if (VOTE_W < 1) begin : g_bad_vote
         $error("VOTE_W must be at least 1");
      end
   endgenerate

   logic signed [NET_W-1:0] net;
   ring_e                   ring_q, ring_d;
   logic [IDX_W-1:0]        idx_q, idx_d;
   logic                    fire_up, fire_dn;
   logic                    up_q, down_q;

   lfr_vote_net #(.VOTE_W(VOTE_W)) u_net (
      .early_i (early_i),
      .late_i  (late_i),
      .net_o   (net)
   );

   lfr_ring_next #(
      .RING_LEN (RING_LEN),
      .NET_W    (NET_W),
      .MAX_STEP (MAX_STEP)
   ) u_next (
      .ring_i    (ring_q),
      .idx_i     (idx_q),
      .net_i     (net),
      .ring_o    (ring_d),
      .idx_o     (idx_d),
      .fire_up_o (fire_up),
      .fire_dn_o (fire_dn)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ring_q <= RING_EARLY;
         idx_q  <= '0;
         up_q   <= 1'b0;
         down_q <= 1'b0;
      end else begin
         ring_q <= ring_d;
         idx_q  <= idx_d;
         up_q   <= fire_up;
         down_q <= fire_dn;
      end
   end

   assign up_o   = up_q;
   assign down_o = down_q;

   // Checker bookkeeping: cycles since the last pulse, saturating.
   logic [GAP_W-1:0] gap_q;
   logic             seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (up_q || down_q) begin
         gap_q  <= GAP_W'(1);
         seen_q <= 1'b1;
      end else if (gap_q < GAP_W'(MIN_GAP)) begin
         gap_q  <= gap_q + GAP_W'(1);
      end
   end

   // R8
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_q && down_q));

   // R8
   up_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_q |=> !up_q);

   // R8
   down_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      down_q |=> !down_q);

   // R9
   pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((up_q || down_q) && seen_q) |-> (gap_q >= GAP_W'(MIN_GAP)));

   // R3
   hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (net == '0) |=> ($stable(idx_q) && $stable(ring_q) && !up_q && !down_q));

   // R4
   up_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(up_q) |-> ($past(net) > 0));

   // R5
   down_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(down_q) |-> ($past(net) < 0));

   // R7
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q < IDX_W'(RING_LEN));

endmodule

// File: tb/sim_lfr_dual_ring.sv
module sim_lfr_dual_ring;

   localparam int RING = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] early_i = '0;
   logic [1:0] late_i = '0;
   logic       up_o, down_o;

   int n_cmp = 0;
   int n_bad = 0;
   int acc = 0;
   int cyc = 0;
   bit exp_up = 1'b0;
   bit exp_dn = 1'b0;
   string req = "R1";
   int pulse_q[$];

   always #2 clk = ~clk;

   lfr_dual_ring u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .early_i (early_i),
      .late_i  (late_i),
      .up_o    (up_o),
      .down_o  (down_o)
   );

   function automatic int ones2(input logic [1:0] v);
      return int'(v[0]) + int'(v[1]);
   endfunction

   task automatic compare();
      n_cmp++;
      if (up_o !== exp_up || down_o !== exp_dn) begin
         n_bad++;
         $display("FAIL %s cycle %0d: up/down actual %b%b expected %b%b",
                  req, cyc, up_o, down_o, exp_up, exp_dn);
      end
      if (up_o === 1'b1 || down_o === 1'b1) begin
         if (pulse_q.size() > 0) begin
            n_cmp++;
            if (cyc - pulse_q[$] < 3) begin
               n_bad++;
               $display("FAIL R9 cycle %0d: pulse gap actual %0d expected >= 3",
                        cyc, cyc - pulse_q[$]);
            end
         end
         pulse_q.push_back(cyc);
      end
   endtask

   // One cycle: check the result of the previous votes, then apply new ones.
   task automatic step(input logic [1:0] e, input logic [1:0] l);
      int t;
      @(negedge clk);
      cyc++;
      compare();
      early_i = e;
      late_i  = l;
      t = acc + ones2(e) - ones2(l);
      exp_up = (t >= RING);
      exp_dn = (t <= -RING);
      if (t >= RING) acc = t - RING;
      else if (t <= -RING) acc = t + RING;
      else acc = t;
   endtask

   task automatic steps(input int n, input logic [1:0] e, input logic [1:0] l);
      for (int i = 0; i < n; i++) step(e, l);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R1: outputs low during reset, even with votes applied
      early_i = 2'b11;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         n_cmp++;
         if (up_o !== 1'b0 || down_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: up/down actual %b%b expected 00", up_o, down_o);
         end
      end
      early_i = '0;
      @(negedge clk);
      rst_n = 1'b1;
      acc = 0; exp_up = 0; exp_dn = 0;

      // R1, R4: six single early steps from entry, up on the sixth
      req = "R4";
      steps(6, 2'b01, 2'b00);
      steps(2, 2'b00, 2'b00);
      // R5: six single late steps
      req = "R5";
      steps(6, 2'b00, 2'b10);
      steps(2, 2'b00, 2'b00);
      // R2: mixed counts, cancelling bits, double steps
      req = "R2";
      steps(4, 2'b11, 2'b01);
      steps(3, 2'b10, 2'b10);
      steps(3, 2'b11, 2'b00);
      steps(4, 2'b00, 2'b11);
      steps(2, 2'b01, 2'b11);
      // R3: zero-step cycles hold the state
      req = "R3";
      steps(2, 2'b01, 2'b00);
      steps(10, 2'b00, 2'b00);
      steps(5, 2'b11, 2'b11);
      steps(6, 2'b01, 2'b00);
      // R6: carry of leftover into the ring
      req = "R6";
      steps(acc < 0 ? -acc : 0, 2'b01, 2'b00);
      steps(acc > 0 ? acc : 0, 2'b00, 2'b01);
      steps(5, 2'b01, 2'b00);
      step(2'b11, 2'b00);
      steps(5, 2'b01, 2'b00);
      steps(5, 2'b00, 2'b01);
      step(2'b00, 2'b11);
      steps(5, 2'b00, 2'b10);
      // R7: opposing moves cross the entry
      req = "R7";
      steps(3, 2'b01, 2'b00);
      steps(4, 2'b00, 2'b11);
      steps(3, 2'b11, 2'b00);
      steps(7, 2'b00, 2'b01);
      // R8, R9: long pseudo-random stream
      req = "R8";
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] r;
         r = 4'($urandom_range(0, 15));
         if (i % 500 < 250) step(r[1:0] | 2'b01, r[3:2] & 2'b01);
         else step(r[1:0], r[3:2]);
      end
      req = "R9";
      steps(12, 2'b11, 2'b00);
      steps(12, 2'b00, 2'b11);
      steps(2, 2'b00, 2'b00);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule